// File: doc/BRIEF.md
# IR Receive Run-Length Sampler

This block watches one consumer-IR receiver pin and turns what it sees into a stream of run-length symbols. The pin first passes through a synchroniser. An optional inversion makes an active-low receiver read as pulse = 1. The block then samples the pin once per sample period, which it derives by dividing the module clock. Each symbol is one byte. Its top bit is the line level and its low seven bits hold the run length in sample periods, minus one. Software multiplies the run length by the sample period to recover pulse and space durations. A FIFO, interrupt logic and protocol decoding all sit outside this block.

Short excursions to the other level are treated as noise and folded back into the run they interrupted. A run of 128 samples or more is split into full-length symbols. A space that lasts up to the idle threshold closes the packet: the pending space symbol is sent together with a one-cycle packet-end pulse. After that the block stays silent until the line returns to pulse.

Symbols leave on a valid/ready port. A symbol stays on `sym_data` with `sym_valid` high until `sym_ready` is seen high at a clock edge. The consumer has one sample period (64 clocks by default) to take each symbol. If a new symbol is produced before the old one is accepted, the new one replaces it. The packet-end pin is a plain pulse and is never held back.

Top module: `ir_rl_sampler`

## Requirements
- R1: After reset `sym_valid` and `pkt_end` are 0. The receiver runs only while `cfg_global_en` and `cfg_rx_en` are both 1 and `cfg_mode` equals 2'b11. Otherwise no symbol and no packet end is produced, whatever the pin does.
- R2: The pin passes through a two-flop synchroniser. While enabled, one sample is taken every DIV (default 64) clocks, the first one DIV clocks after enabling. A level held over a whole sample period is the level that is sampled.
- R3: Symbol bit 7 is the level (1 = pulse, 0 = space) and bits 6:0 are the run length in samples minus one. A run's symbol is emitted when the change to the other level is confirmed.
- R4: A new level is confirmed once it has lasted max(`cfg_noise_thr`,1) consecutive samples, and those samples open the new run. A shorter excursion is counted into the current run.
- R5: When a run reaches 128 samples, a symbol with length field 127 is emitted and counting restarts for the same level.
- R6: When a space that is not yet idle reaches `cfg_idle_thr` samples (0 disables this), the pending space symbol is emitted and `pkt_end` pulses for one cycle together with `sym_valid`. After that no symbol is emitted until a pulse is confirmed. The receiver also starts in this idle state when enabled.
- R7: If the idle threshold and the 128-sample limit are reached on the same sample, exactly one symbol is emitted, space with length field 127, together with `pkt_end`.
- R8: `sym_data` stays stable and `sym_valid` stays high until `sym_ready` is seen high. A newer symbol replaces one that has not been accepted. `sym_valid` drops one cycle after acceptance.
- R9: With `cfg_invert` = 1 the synchronised pin is inverted before sampling, so a low pin reads as pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Raw receiver pin |
| cfg_global_en | input | 1 | Global enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_mode | input | 2 | Operating mode; 2'b11 selects IR sampling |
| cfg_invert | input | 1 | Invert the pin before sampling |
| cfg_noise_thr | input | 6 | Samples needed to confirm a level change |
| cfg_idle_thr | input | 8 | Space samples that end a packet; 0 disables |
| sym_valid | output | 1 | Symbol available |
| sym_ready | input | 1 | Consumer accepts the symbol |
| sym_data | output | 8 | {level, run length minus one} |
| pkt_end | output | 1 | One-cycle end-of-packet pulse |

## Verification
Two functions can act on the same sample. One is the split of a long run at 128 samples. The other is the packet close at the idle threshold. The bench provokes the overlap by setting the idle threshold to 128 and sending a space of well over 128 samples. It then checks that exactly one space symbol of full length appears, that it carries the packet-end pulse, and that no second split symbol follows. The same comparison also checks that `pkt_end` arrives in the same cycle as the closing symbol in every random run.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;
  localparam logic [1:0] MODE_IR_SAMPLE = 2'b11;
  localparam int unsigned DEF_DIV        = 64;
  localparam int unsigned DEF_LEN_W      = 7;
endpackage

// File: rtl/ir_rl_sync.sv
module ir_rl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ir_rl_tick_div.sv
module ir_rl_tick_div #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run_en)        cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + CW'(1);
  end

  assign tick = run_en && (cnt_q == LAST);

  // R2: ticks are never back to back
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/ir_rl_core.sv
module ir_rl_core #(
  parameter int NTHR_W = 6,
  parameter int ITHR_W = 8,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              tick,
  input  logic              sample,
  input  logic [NTHR_W-1:0] noise_thr,
  input  logic [ITHR_W-1:0] idle_thr,
  output logic              emit,
  output logic [LEN_W:0]    emit_sym,
  output logic              emit_pkt
);
  localparam int RUN_W = LEN_W + 1;
  localparam int SUM_W = RUN_W + 1;
  localparam int SP_W  = ITHR_W + 1;
  localparam logic [SUM_W-1:0] MAX_RUN = SUM_W'(1) << LEN_W;

  logic              lvl_q, lvl_d;
  logic              idle_q, idle_d;
  logic [RUN_W-1:0]  run_q, run_d;
  logic [NTHR_W-1:0] cand_q, cand_d;
  logic [ITHR_W-1:0] sp_q, sp_d;

  logic [NTHR_W-1:0] need;
  logic [NTHR_W:0]   cand_nx;
  logic [SUM_W-1:0]  add_w, newrun;
  logic [SP_W-1:0]   sp_sum;
  logic [ITHR_W-1:0] sp_sat;
  logic              idle_hit, sat_hit;

  always_comb begin
    need     = (noise_thr == '0) ? NTHR_W'(1) : noise_thr;
    cand_nx  = {1'b0, cand_q} + (NTHR_W+1)'(1);
    add_w    = SUM_W'(cand_q) + SUM_W'(1);
    newrun   = SUM_W'(run_q) + add_w;
    sp_sum   = {1'b0, sp_q} + SP_W'(add_w);
    sp_sat   = sp_sum[ITHR_W] ? '1 : sp_sum[ITHR_W-1:0];
    idle_hit = !lvl_q && (idle_thr != '0) && (sp_sat >= idle_thr);
    sat_hit  = (newrun >= MAX_RUN);
  end

  always_comb begin
    lvl_d    = lvl_q;
    idle_d   = idle_q;
    run_d    = run_q;
    cand_d   = cand_q;
    sp_d     = sp_q;
    emit     = 1'b0;
    emit_sym = '0;
    emit_pkt = 1'b0;
    if (tick) begin
      if (sample == lvl_q) begin
        cand_d = '0;
        if (!idle_q) begin
          if (idle_hit) begin
            emit     = 1'b1;
            emit_pkt = 1'b1;
            emit_sym = {1'b0, sat_hit ? {LEN_W{1'b1}} : LEN_W'(newrun - SUM_W'(1))};
            idle_d   = 1'b1;
            run_d    = '0;
            sp_d     = '0;
          end else if (sat_hit) begin
            emit     = 1'b1;
            emit_sym = {lvl_q, {LEN_W{1'b1}}};
            run_d    = RUN_W'(newrun - MAX_RUN);
            sp_d     = lvl_q ? '0 : sp_sat;
          end else begin
            run_d    = RUN_W'(newrun);
            sp_d     = lvl_q ? '0 : sp_sat;
          end
        end
      end else if (cand_nx >= {1'b0, need}) begin
        if (!idle_q && run_q != '0) begin
          emit     = 1'b1;
          emit_sym = {lvl_q, LEN_W'(run_q - RUN_W'(1))};
        end
        lvl_d  = sample;
        run_d  = RUN_W'(cand_nx);
        sp_d   = sample ? '0 : ITHR_W'(cand_nx);
        idle_d = 1'b0;
        cand_d = '0;
      end else begin
        cand_d = NTHR_W'(cand_nx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0; idle_q <= 1'b1; run_q <= '0; cand_q <= '0; sp_q <= '0;
    end else if (!run_en) begin
      lvl_q <= 1'b0; idle_q <= 1'b1; run_q <= '0; cand_q <= '0; sp_q <= '0;
    end else begin
      lvl_q <= lvl_d; idle_q <= idle_d; run_q <= run_d; cand_q <= cand_d; sp_q <= sp_d;
    end
  end

  // R1: a disabled receiver emits nothing
  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !emit);
  // R6: packet end always travels with a space symbol
  p_pkt_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
    emit_pkt |-> (emit && !emit_sym[LEN_W]));
  // R6: after packet end the receiver is idle
  p_pkt_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_pkt && run_en) |=> idle_q);
  // R5: a short symbol outside packet close comes only from a level change
  p_short_needs_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !emit_pkt && emit_sym[LEN_W-1:0] != {LEN_W{1'b1}}) |-> (sample != lvl_q));
endmodule

// File: rtl/ir_rl_sym_out.sv
module ir_rl_sym_out #(
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SYM_W-1:0] load_sym,
  input  logic             load_pkt,
  input  logic             ready,
  output logic             valid,
  output logic [SYM_W-1:0] data,
  output logic             pkt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      pkt   <= 1'b0;
    end else begin
      pkt <= load_pkt;
      if (load) begin
        valid <= 1'b1;
        data  <= load_sym;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end

  // R8: an unaccepted symbol is held
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(data)));
  // R6: the packet-end pulse coincides with a valid symbol
  p_pkt_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt |-> valid);
endmodule

// File: rtl/ir_rl_sampler.sv
module ir_rl_sampler
  import ir_rl_pkg::*;
#(
  parameter int DIV         = DEF_DIV,
  parameter int SYNC_STAGES = 2,
  parameter int NTHR_W      = 6,
  parameter int ITHR_W      = 8,
  parameter int LEN_W       = DEF_LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic              cfg_global_en,
  input  logic              cfg_rx_en,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_invert,
  input  logic [NTHR_W-1:0] cfg_noise_thr,
  input  logic [ITHR_W-1:0] cfg_idle_thr,
  output logic              sym_valid,
  input  logic              sym_ready,
  output logic [LEN_W:0]    sym_data,
  output logic              pkt_end
);
  localparam int SYM_W = LEN_W + 1;

  logic run_en, tick, rx_sync, sample;
  logic emit, emit_pkt;
  logic [SYM_W-1:0] emit_sym;

  assign run_en = cfg_global_en && cfg_rx_en && (cfg_mode == MODE_IR_SAMPLE);

  ir_rl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_sync));

  assign sample = rx_sync ^ cfg_invert;

  ir_rl_tick_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick));

  ir_rl_core #(.NTHR_W(NTHR_W), .ITHR_W(ITHR_W), .LEN_W(LEN_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick), .sample(sample),
    .noise_thr(cfg_noise_thr), .idle_thr(cfg_idle_thr),
    .emit(emit), .emit_sym(emit_sym), .emit_pkt(emit_pkt));

  ir_rl_sym_out #(.SYM_W(SYM_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(emit), .load_sym(emit_sym),
    .load_pkt(emit_pkt), .ready(sym_ready),
    .valid(sym_valid), .data(sym_data), .pkt(pkt_end));
endmodule

// File: tb/ir_rl_sampler_test.sv
module ir_rl_sampler_test;
  localparam int DIV    = 64;
  localparam int MARKER = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b0;
  logic gen = 1'b0, rxen = 1'b0, inv = 1'b0, rdy = 1'b1;
  logic [1:0] mode = 2'b11;
  logic [5:0] nthr = 6'd1;
  logic [7:0] ithr = 8'd20;
  logic sym_valid, pkt_end;
  logic [7:0] sym_data;

  int total = 0, failed = 0;
  bit done = 0;
  bit smp_q[$];
  int exp_q[$];
  int obs_q[$];

  always #10 clk = ~clk;

  ir_rl_sampler uut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .cfg_global_en(gen), .cfg_rx_en(rxen),
    .cfg_mode(mode), .cfg_invert(inv), .cfg_noise_thr(nthr), .cfg_idle_thr(ithr),
    .sym_valid(sym_valid), .sym_ready(rdy), .sym_data(sym_data), .pkt_end(pkt_end));

  always @(negedge clk) begin
    if (rst_n) begin
      if (sym_valid && rdy) obs_q.push_back(int'(sym_data));
      if (pkt_end) obs_q.push_back(MARKER);
    end
  end

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic void model(input int nt, input int it);
    int lvl = 0, idle = 1, run = 0, cand = 0, sp = 0, need, add, nr, ns;
    need = (nt == 0) ? 1 : nt;
    exp_q.delete();
    foreach (smp_q[i]) begin
      if (int'(smp_q[i]) == lvl) begin
        add = cand + 1; cand = 0;
        if (idle == 0) begin
          nr = run + add;
          ns = (lvl == 1) ? 0 : ((sp + add > 255) ? 255 : sp + add);
          if (lvl == 0 && it != 0 && ns >= it) begin
            exp_q.push_back((nr >= 128) ? 127 : nr - 1);
            exp_q.push_back(MARKER);
            idle = 1; run = 0; sp = 0;
          end else if (nr >= 128) begin
            exp_q.push_back(lvl * 128 + 127);
            run = nr - 128; sp = ns;
          end else begin
            run = nr; sp = ns;
          end
        end
      end else if (cand + 1 >= need) begin
        if (idle == 0 && run > 0) exp_q.push_back(lvl * 128 + run - 1);
        lvl = int'(smp_q[i]); run = cand + 1;
        sp = (lvl == 1) ? 0 : cand + 1;
        idle = 0; cand = 0;
      end else begin
        cand++;
      end
    end
  endfunction

  function automatic void add_run(input bit lv, input int n);
    for (int k = 0; k < n; k++) smp_q.push_back(lv);
  endfunction

  task automatic run_scn(input string req, input int nt, input int it, input bit iv);
    @(negedge clk);
    obs_q.delete();
    nthr = 6'(nt); ithr = 8'(it); inv = iv; mode = 2'b11; rdy = 1'b1;
    gen = 1'b1; rxen = 1'b1;
    for (int k = 0; k < smp_q.size(); k++) begin
      rx_in = smp_q[k] ^ iv;
      repeat (DIV) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    gen = 1'b0;
    repeat (4) @(negedge clk);
    model(nt, it);
    check({req, " symbol count"}, obs_q.size(), exp_q.size());
    for (int k = 0; k < exp_q.size() && k < obs_q.size(); k++)
      check({req, " symbol value"}, obs_q[k], exp_q[k]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5A_0C3B));
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(sym_valid), 0);
    check("R1 reset pkt_end", int'(pkt_end), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: wrong mode means no output
    obs_q.delete();
    gen = 1'b1; rxen = 1'b1; mode = 2'b01;
    for (int k = 0; k < 20; k++) begin
      rx_in = k[1];
      repeat (DIV) @(negedge clk);
    end
    gen = 1'b0; mode = 2'b11;
    repeat (4) @(negedge clk);
    check("R1 disabled output count", obs_q.size(), 0);

    // R5: long pulse split at 128 samples, then R6 close
    smp_q.delete(); add_run(1, 300); add_run(0, 25);
    run_scn("R5 saturation", 1, 20, 0);
    check("R5 first full pulse", (obs_q.size() > 0) ? obs_q[0] : -1, 8'hFF);

    // R4: glitches merged, including one while idle
    smp_q.delete();
    add_run(0, 5); add_run(1, 2); add_run(0, 5);
    add_run(1, 10); add_run(0, 2); add_run(1, 10); add_run(0, 40);
    run_scn("R4 noise merge", 3, 30, 0);
    check("R4 merged pulse 22", (obs_q.size() > 0) ? obs_q[0] : -1, 8'h95);

    // R7: idle threshold 128 meets the split limit on the same sample
    smp_q.delete(); add_run(1, 5); add_run(0, 140);
    run_scn("R7 collision", 1, 128, 0);
    check("R7 pulse symbol", obs_q.size(), 3);
    check("R7 single full space", (obs_q.size() > 1) ? obs_q[1] : -1, 8'h7F);
    check("R7 packet end", (obs_q.size() > 2) ? obs_q[2] : -1, MARKER);

    // R9: inverted pin
    smp_q.delete(); add_run(1, 7); add_run(0, 4); add_run(1, 3); add_run(0, 25);
    run_scn("R9 invert", 1, 20, 1);
    check("R9 R3 first pulse", (obs_q.size() > 0) ? obs_q[0] : -1, 8'h86);

    // R8: back-pressure hold and replacement
    @(negedge clk);
    rdy = 1'b0; nthr = 6'd1; ithr = 8'd0; inv = 1'b0; mode = 2'b11;
    gen = 1'b1; rxen = 1'b1; rx_in = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    rx_in = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    rx_in = 1'b1;
    repeat (276 - 6 * DIV) @(negedge clk);
    check("R8 held valid", int'(sym_valid), 1);
    check("R8 R3 held data", int'(sym_data), 8'h82);
    repeat (180) @(negedge clk);
    check("R8 replaced data", int'(sym_data), 8'h02);
    rdy = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 valid drops after accept", int'(sym_valid), 0);
    gen = 1'b0;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R6: random traffic against the bench model
    for (int s = 0; s < 4; s++) begin
      int nt, it, lv, len;
      nt = int'($urandom % 4);
      it = 20 + int'($urandom % 40);
      smp_q.delete();
      lv = 1;
      while (smp_q.size() < 220) begin
        len = 1 + int'($urandom % 40);
        add_run(lv[0], len);
        if ($urandom % 4 == 0) begin
          add_run(!lv[0], 1 + int'($urandom % 3));
          add_run(lv[0], 1 + int'($urandom % 10));
        end
        lv = 1 - lv;
      end
      add_run(0, it + 5);
      run_scn("R2 R6 random", nt, it, s[0]);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule